// File: doc/BRIEF.md
# Multi-Mode Shift Register Unit

This block is a clocked data register of parameterised width (default 8 bits) whose content changes once per clock according to a 3-bit operation code. The register can keep its value, take a new value from a parallel input, or move every bit by exactly one position. Six single-position moves are offered: a plain move left or right that brings in a zero, a rotation left or right that brings in the bit pushed out of the other end, and a signed move left or right that treats the register as a two's-complement number.

The signed moves double or halve a signed value. A signed right move keeps the most significant bit in place and also copies it one position down. A signed left move brings a zero into the least significant bit. A registered overflow flag reports a signed left move that changed the sign, which happens exactly when the two top bits differed before the move. Any other operation clears the flag.

The reset input acts at once when it goes low. Its release passes through a short synchroniser, so the register starts acting on operation codes a fixed number of clock edges after the release.

Top module: `shreg_unit`

## Requirements
- R1: Operation code 0 (keep) leaves the register unchanged, whatever the data input holds.
- R2: Operation code 1 (parallel load) puts the data input into the register at the next rising clock edge.
- R3: Codes 2 (plain left, toward the most significant bit) and 3 (plain right) move the register by one position and put 0 into the vacated bit.
- R4: Codes 4 (rotate left) and 5 (rotate right) move the register by one position and put the bit that left at one end into the vacated bit at the other end.
- R5: Code 7 (signed right) keeps the most significant bit, copies it into the bit below, and moves all lower bits one position down.
- R6: Code 6 (signed left) moves the register one position up with 0 entering the least significant bit. The overflow output is 1 after the edge exactly when the two most significant bits differed before it.
- R7: The overflow output is 0 after any edge whose operation code is not 6.
- R8: A low reset input clears the register and the overflow output at once. After the reset input goes high, the first operation takes effect at the third rising clock edge, with the default of two synchroniser stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| mode | input | 3 | Operation code: 0 keep, 1 load, 2 plain left, 3 plain right, 4 rotate left, 5 rotate right, 6 signed left, 7 signed right |
| din | input | WIDTH | Parallel data for the load operation |
| q | output | WIDTH | Current register content |
| ovf | output | 1 | Registered sign-change flag of the last signed left move |

## Verification
The register content and the overflow flag both leave the block straight from flops, so a wrong next-state value or a wrong fill bit appears at `q` one clock edge after the operation that caused it. The wrong bit then stays visible until a later operation moves it or overwrites it. Fill errors show up in the vacated bit only, which is why the stimulus uses patterns whose end bits differ and follows each move with a move the other way. A stale or sticky overflow flag is exposed by running a non-overflowing operation right after an overflowing signed left move. A late or early reset release shows as a load that takes effect one edge off.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  typedef enum logic [2:0] {
    MODE_KEEP = 3'd0,
    MODE_LOAD = 3'd1,
    MODE_LSL  = 3'd2,
    MODE_LSR  = 3'd3,
    MODE_ROTL = 3'd4,
    MODE_ROTR = 3'd5,
    MODE_ASL  = 3'd6,
    MODE_ASR  = 3'd7
  } mode_e;

  function automatic logic is_up_move(mode_e m);
    return (m == MODE_LSL) || (m == MODE_ROTL) || (m == MODE_ASL);
  endfunction

  function automatic logic is_down_move(mode_e m);
    return (m == MODE_LSR) || (m == MODE_ROTR) || (m == MODE_ASR);
  endfunction

endpackage

// File: rtl/shreg_rst_sync.sv
module shreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/shreg_fill_sel.sv
module shreg_fill_sel
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_e             mode,
  input  logic [WIDTH-1:0]  q,
  output logic              fill_lsb,
  output logic              fill_msb
);

  localparam int TOP = WIDTH - 1;

  // Bit entering position 0 on an upward move.
  always_comb begin
    unique case (mode)
      MODE_ROTL: fill_lsb = q[TOP];
      default:   fill_lsb = 1'b0;
    endcase
  end

  // Bit entering the top position on a downward move.
  always_comb begin
    unique case (mode)
      MODE_ROTR: fill_msb = q[0];
      MODE_ASR:  fill_msb = q[TOP];
      default:   fill_msb = 1'b0;
    endcase
  end

endmodule

// File: rtl/shreg_next_state.sv
module shreg_next_state
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_e             mode,
  input  logic [WIDTH-1:0]  q,
  input  logic [WIDTH-1:0]  din,
  input  logic              fill_lsb,
  input  logic              fill_msb,
  output logic [WIDTH-1:0]  q_nxt,
  output logic              q_en
);

  localparam int TOP = WIDTH - 1;

  logic up_move;
  logic down_move;

  always_comb begin
    up_move   = is_up_move(mode);
    down_move = is_down_move(mode);
    q_en      = (mode != MODE_KEEP);
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_below;
    logic from_above;

    if (i == 0) begin : g_lsb
      assign from_below = fill_lsb;
    end else begin : g_mid_lo
      assign from_below = q[i-1];
    end

    if (i == TOP) begin : g_msb
      assign from_above = fill_msb;
    end else begin : g_mid_hi
      assign from_above = q[i+1];
    end

    always_comb begin
      if (mode == MODE_LOAD) begin
        q_nxt[i] = din[i];
      end else if (up_move) begin
        q_nxt[i] = from_below;
      end else if (down_move) begin
        q_nxt[i] = from_above;
      end else begin
        q_nxt[i] = q[i];
      end
    end
  end

endmodule

// File: rtl/shreg_unit.sv
module shreg_unit
  import shreg_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [WIDTH-1:0]  din,
  output logic [WIDTH-1:0]  q,
  output logic              ovf
);

  localparam int TOP = WIDTH - 1;

  mode_e             mode_dec;
  logic              rst_sync_n;
  logic              fill_lsb;
  logic              fill_msb;
  logic [WIDTH-1:0]  q_nxt;
  logic              q_en;
  logic              ovf_nxt;
  logic [WIDTH-1:0]  q_r;
  logic              ovf_r;

  assign mode_dec = mode_e'(mode);

  shreg_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  shreg_fill_sel #(
    .WIDTH(WIDTH)
  ) u_fill (
    .mode    (mode_dec),
    .q       (q_r),
    .fill_lsb(fill_lsb),
    .fill_msb(fill_msb)
  );

  shreg_next_state #(
    .WIDTH(WIDTH)
  ) u_next (
    .mode    (mode_dec),
    .q       (q_r),
    .din     (din),
    .fill_lsb(fill_lsb),
    .fill_msb(fill_msb),
    .q_nxt   (q_nxt),
    .q_en    (q_en)
  );

  // Sign change on a signed upward move: top two bits disagree beforehand.
  always_comb begin
    if (mode_dec == MODE_ASL) begin
      ovf_nxt = q_r[TOP] ^ q_r[TOP-1];
    end else begin
      ovf_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q_r <= '0;
    end else if (q_en) begin
      q_r <= q_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ovf_r <= 1'b0;
    end else begin
      ovf_r <= ovf_nxt;
    end
  end

  assign q   = q_r;
  assign ovf = ovf_r;

endmodule

// File: rtl/shreg_unit_chk.sv
module shreg_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic [2:0]        mode,
  input logic [WIDTH-1:0]  din,
  input logic [WIDTH-1:0]  q,
  input logic              ovf
);

  localparam int TOP = WIDTH - 1;

  AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd0) |=> $stable(q));  // R1

  AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd1) |=> (q == $past(din)));  // R2

  AST_PLAIN_LEFT_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd2) |=> (q == {$past(q[TOP-1:0]), 1'b0}));  // R3

  AST_PLAIN_RIGHT_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd3) |=> (q == {1'b0, $past(q[TOP:1])}));  // R3

  AST_ROT_LEFT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd4) |=> (q == {$past(q[TOP-1:0]), $past(q[TOP])}));  // R4

  AST_ROT_RIGHT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd5) |=> (q == {$past(q[0]), $past(q[TOP:1])}));  // R4

  AST_SIGNED_RIGHT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd7) |=> (q == {$past(q[TOP]), $past(q[TOP:1])}));  // R5

  AST_SIGNED_LEFT_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 3'd6) |=> (ovf == ($past(q[TOP]) ^ $past(q[TOP-1]))));  // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode != 3'd6) |=> !ovf);  // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> ((q == '0) && !ovf));  // R8

endmodule

bind shreg_unit shreg_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/shreg_unit_test.sv
module shreg_unit_test;

  localparam int W = 8;

  typedef struct packed {
    logic [2:0]   mode;
    logic [W-1:0] din;
    logic [W-1:0] exp_q;
    logic         exp_ovf;
    logic [3:0]   req;
  } vec_t;

  localparam int NVEC = 20;

  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 8'hB4, 8'hB4, 1'b0, 4'd2},  // R2 load
    '{3'd2, 8'h00, 8'h68, 1'b0, 4'd3},  // R3 plain left
    '{3'd3, 8'hFF, 8'h34, 1'b0, 4'd3},  // R3 plain right
    '{3'd1, 8'h81, 8'h81, 1'b0, 4'd2},  // R2 load
    '{3'd4, 8'h00, 8'h03, 1'b0, 4'd4},  // R4 rotate left wraps msb
    '{3'd5, 8'h00, 8'h81, 1'b0, 4'd4},  // R4 rotate right wraps lsb
    '{3'd5, 8'h00, 8'hC0, 1'b0, 4'd4},  // R4 rotate right
    '{3'd7, 8'h00, 8'hE0, 1'b0, 4'd5},  // R5 signed right negative
    '{3'd6, 8'h00, 8'hC0, 1'b0, 4'd6},  // R6 top bits 11
    '{3'd6, 8'h00, 8'h80, 1'b0, 4'd6},  // R6 top bits 11
    '{3'd6, 8'h00, 8'h00, 1'b1, 4'd6},  // R6 top bits 10
    '{3'd0, 8'h5A, 8'h00, 1'b0, 4'd7},  // R7 keep clears flag
    '{3'd1, 8'h40, 8'h40, 1'b0, 4'd2},  // R2 load
    '{3'd6, 8'h00, 8'h80, 1'b1, 4'd6},  // R6 top bits 01
    '{3'd3, 8'h00, 8'h40, 1'b0, 4'd7},  // R7 plain right clears flag
    '{3'd7, 8'h00, 8'h20, 1'b0, 4'd5},  // R5 signed right positive
    '{3'd0, 8'hFF, 8'h20, 1'b0, 4'd1},  // R1 keep ignores din
    '{3'd6, 8'h00, 8'h40, 1'b0, 4'd6},  // R6 top bits 00
    '{3'd6, 8'h00, 8'h80, 1'b1, 4'd6},  // R6 top bits 01
    '{3'd7, 8'h00, 8'hC0, 1'b0, 4'd7}   // R7 signed right clears flag
  };

  logic         clk;
  logic         rst_n;
  logic [2:0]   mode;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic         ovf;

  int checks;
  int errors;
  bit done;

  shreg_unit #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (mode),
    .din  (din),
    .q    (q),
    .ovf  (ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic [W-1:0] d);
    @(negedge clk);
    mode = m;
    din  = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    mode   = 3'd0;
    din    = '0;
    repeat (3) @(posedge clk);
    #1;
    check(q, 8'h00, "R8 reset q");
    check({7'b0, ovf}, 8'h00, "R8 reset ovf");

    // Release with load pending: no effect on edges 1 and 2, effect on edge 3.
    @(negedge clk);
    rst_n = 1'b1;
    mode  = 3'd1;
    din   = 8'h3C;
    @(posedge clk); #1;
    check(q, 8'h00, "R8 release edge1");
    @(posedge clk); #1;
    check(q, 8'h00, "R8 release edge2");
    @(posedge clk); #1;
    check(q, 8'h3C, "R8 release edge3");
    step(3'd0, 8'h00);
    check(q, 8'h3C, "R1 keep after load");

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].mode, VECS[i].din);
      check(q, VECS[i].exp_q, $sformatf("R%0d vec%0d q", VECS[i].req, i));
      check({7'b0, ovf}, {7'b0, VECS[i].exp_ovf},
            $sformatf("R%0d vec%0d ovf", VECS[i].req, i));
    end

    // Corner: rotate right with single lsb set, then plain left drops msb.
    step(3'd1, 8'h01);
    step(3'd5, 8'h00);
    check(q, 8'h80, "R4 rotate right lsb to msb");
    step(3'd2, 8'h00);
    check(q, 8'h00, "R3 plain left drops msb");

    // Corner: overflow set then reset asserted mid-cycle clears at once.
    step(3'd1, 8'h7F);
    step(3'd6, 8'h00);
    check(q, 8'hFE, "R6 signed left of 7F");
    check({7'b0, ovf}, 8'h01, "R6 overflow 7F");
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check(q, 8'h00, "R8 async clear q");
    check({7'b0, ovf}, 8'h00, "R8 async clear ovf");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule